// File: doc/BRIEF.md
# Two-Bank Daisy-Chain DAC Frame Loader

This block feeds sixteen serially loaded DAC devices that sit on two daisy chains of eight. The first chain (bank A) carries channels 1 to 8 and the second (bank B) carries channels 9 to 16. Both chains share one serial clock and one load strobe, and each chain has its own data line. Every device expects a 32-bit frame. The frame holds a command word that selects the output range and the buffer action, followed by a data word that holds the output code. Each channel has a command register and a data register, and a simple write port fills them.

Setting the arm bit starts a pass. In a pass both chains shift their eight frames in parallel. The frame for the device furthest from the driver goes out first, so every frame ends up in its own device. After the last bit, one load pulse makes all sixteen outputs change together. In register mode the arm bit clears itself when the load pulse ends. In memory mode it stays set, and passes repeat back to back from the current register contents until software clears arm. The registers may be rewritten at any time. Each frame is taken from the registers at the moment that frame starts shifting.

Top module: `dac_chain_loader`

## Requirements
- R1: A pass sends exactly 32 bits per device on each chain (256 bits per chain with 8 devices). Each frame is the 16-bit command word followed by the 16-bit data word, and each word is sent most significant bit first.
- R2: The command word sent for a channel is 8'h00, then the stored 4-bit range code, then 4'h0 (code in bits 7:4). A command write stores only wr_data[7:4]. All other bits of the written value have no effect on the frame.
- R3: On bank A the frames go out in channel order 8,7,...,1 (register indices 7 down to 0). At the same time bank B sends 16,...,9 (indices 15 down to 8).
- R4: The serial clock idles low and has a period of 2*HALF_DIV clocks, with the high phase lasting HALF_DIV clocks. Serial data changes only as the clock falls and is stable while it is high.
- R5: After the last bit of a pass there is exactly one load pulse. It lasts LOAD_PERIODS serial periods (2*LOAD_PERIODS*HALF_DIV clocks), and the serial clock stays low throughout.
- R6: In register mode (mem_mode=0) the arm bit clears at the end of the load pulse, and no further pass starts.
- R7: In memory mode (mem_mode=1) arm stays set and passes repeat. A register write made before a frame starts shifting appears in that frame of the next pass.
- R8: Reset clears every command and data register, arm, the serial clock, both data lines and the load strobe. A pass started before any write sends all-zero frames.
- R9: arm_clr clears arm. A pass already in progress completes with its load pulse, and no new pass starts. When arm_set and arm_clr occur in the same cycle, arm ends up set.
- R10: The load pulse rises exactly 1 + 64*CH_PER_BANK*HALF_DIV clocks after the edge that samples arm_set from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_cmd | input | 1 | 1 selects the command register, 0 the data register |
| wr_ch | input | 4 | Channel index 0..15 (0..7 bank A, 8..15 bank B) |
| wr_data | input | 16 | Write value |
| arm_set | input | 1 | Sets the arm bit |
| arm_clr | input | 1 | Clears the arm bit |
| mem_mode | input | 1 | 1 keeps arm set and repeats passes |
| arm | output | 1 | Arm bit |
| sclk | output | 1 | Serial clock shared by both chains |
| sdo_a | output | 1 | Serial data to bank A |
| sdo_b | output | 1 | Serial data to bank B |
| ld | output | 1 | Common load strobe, active high |

## Verification
The bench builds the block with HALF_DIV=2, so one serial period is four clocks and a full pass takes about a thousand cycles. At that length the bench can run six passes, several of them back to back in memory mode. It keeps CH_PER_BANK at 8 and LOAD_PERIODS at 2, so the furthest-first ordering is checked over full-length chains and the load pulse spans more than one serial period. The latency check compares the arm-to-strobe delay against the closed-form count for these values.

// File: rtl/dacl_pkg.sv
package dacl_pkg;
    localparam int CODE_W   = 4;
    localparam int CODE_LSB = 4;
    localparam int WORD_W   = 16;
    localparam int FRAME_W  = 2 * WORD_W;
    localparam int BIT_W    = $clog2(FRAME_W);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] value;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_LOAD  = 2'd2
    } seq_state_e;

    // command word first, data word last
    function automatic logic [FRAME_W-1:0] build_frame(chan_cfg_t c);
        logic [WORD_W-1:0] cmd_word;
        cmd_word = '0;
        cmd_word[CODE_LSB +: CODE_W] = c.code;
        return {cmd_word, c.value};
    endfunction
endpackage

// File: rtl/dacl_regs.sv
module dacl_regs
    import dacl_pkg::*;
#(
    parameter int NCH = 16,
    parameter int IW  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_cmd,
    input  logic [IW-1:0]           wr_ch,
    input  logic [WORD_W-1:0]       wr_data,
    output chan_cfg_t [NCH-1:0]     cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_ch == IW'(i)) begin
                    if (wr_cmd) cfg[i].code  <= wr_data[CODE_LSB +: CODE_W];
                    else        cfg[i].value <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/dacl_tick.sv
module dacl_tick #(
    parameter int HALF_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dacl_seq.sv
module dacl_seq
    import dacl_pkg::*;
#(
    parameter int CH_PER_BANK  = 8,
    parameter int LOAD_PERIODS = 2,
    parameter int NCH          = 16,
    parameter int IW           = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                arm_set,
    input  logic                arm_clr,
    input  logic                mem_mode,
    input  chan_cfg_t [NCH-1:0] cfg,
    output logic                idle,
    output logic                arm,
    output logic                sclk,
    output logic                sdo_a,
    output logic                sdo_b,
    output logic                ld
);
    localparam int SW       = (CH_PER_BANK > 1) ? $clog2(CH_PER_BANK) : 1;
    localparam int LCW      = $clog2(2 * LOAD_PERIODS) > 0 ? $clog2(2 * LOAD_PERIODS) : 1;
    localparam logic [SW-1:0]    LAST_SLOT = SW'(CH_PER_BANK - 1);
    localparam logic [LCW-1:0]   LAST_HALF = LCW'(2 * LOAD_PERIODS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);

    seq_state_e         state;
    logic               phase;
    logic [BIT_W-1:0]   bitc;
    logic [SW-1:0]      slot;
    logic [LCW-1:0]     lcnt;
    logic [FRAME_W-1:0] sha, shb;
    logic [SW-1:0]      fslot;
    logic [IW-1:0]      ia, ib;
    logic [FRAME_W-1:0] frame_a, frame_b;
    logic               end_pass;

    // furthest device of each chain is fed first
    always_comb begin
        fslot   = (state == SEQ_IDLE) ? '0 : slot + 1'b1;
        ia      = IW'(CH_PER_BANK - 1) - IW'(fslot);
        ib      = IW'(NCH - 1) - IW'(fslot);
        frame_a = build_frame(cfg[ia]);
        frame_b = build_frame(cfg[ib]);
    end

    assign end_pass = (state == SEQ_LOAD) && tick && (lcnt == LAST_HALF);
    assign idle     = (state == SEQ_IDLE);
    assign sclk     = phase;
    assign sdo_a    = sha[FRAME_W-1];
    assign sdo_b    = shb[FRAME_W-1];
    assign ld       = (state == SEQ_LOAD);

    always_ff @(posedge clk) begin
        if (rst)                           arm <= 1'b0;
        else if (arm_set)                  arm <= 1'b1;
        else if (arm_clr)                  arm <= 1'b0;
        else if (end_pass && !mem_mode)    arm <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            phase <= 1'b0;
            bitc  <= '0;
            slot  <= '0;
            lcnt  <= '0;
            sha   <= '0;
            shb   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (arm) begin
                        state <= SEQ_SHIFT;
                        sha   <= frame_a;
                        shb   <= frame_b;
                        slot  <= '0;
                        bitc  <= '0;
                        phase <= 1'b0;
                    end
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (bitc == LAST_BIT) begin
                                bitc <= '0;
                                if (slot == LAST_SLOT) begin
                                    state <= SEQ_LOAD;
                                    lcnt  <= '0;
                                    sha   <= '0;
                                    shb   <= '0;
                                end else begin
                                    slot <= slot + 1'b1;
                                    sha  <= frame_a;
                                    shb  <= frame_b;
                                end
                            end else begin
                                bitc <= bitc + 1'b1;
                                sha  <= sha << 1;
                                shb  <= shb << 1;
                            end
                        end
                    end
                end
                SEQ_LOAD: begin
                    if (tick) begin
                        if (lcnt == LAST_HALF) state <= SEQ_IDLE;
                        else                   lcnt  <= lcnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
    import dacl_pkg::*;
#(
    parameter int CH_PER_BANK  = 8,
    parameter int HALF_DIV     = 16,
    parameter int LOAD_PERIODS = 2,
    localparam int NCH         = 2 * CH_PER_BANK,
    localparam int IW          = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_cmd,
    input  logic [IW-1:0]     wr_ch,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              mem_mode,
    output logic              arm,
    output logic              sclk,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              ld
);
    chan_cfg_t [NCH-1:0] cfg;
    logic                idle;
    logic                tick;

    dacl_regs #(.NCH(NCH), .IW(IW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_ch(wr_ch), .wr_data(wr_data), .cfg(cfg)
    );

    dacl_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst(rst), .clr(idle), .tick(tick)
    );

    dacl_seq #(
        .CH_PER_BANK(CH_PER_BANK), .LOAD_PERIODS(LOAD_PERIODS),
        .NCH(NCH), .IW(IW)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .arm_set(arm_set),
        .arm_clr(arm_clr), .mem_mode(mem_mode), .cfg(cfg), .idle(idle),
        .arm(arm), .sclk(sclk), .sdo_a(sdo_a), .sdo_b(sdo_b), .ld(ld)
    );
endmodule

// File: rtl/dac_chain_loader_chk.sv
module dac_chain_loader_chk #(
    parameter int HALF_DIV     = 16,
    parameter int LOAD_PERIODS = 2
) (
    input logic clk,
    input logic rst,
    input logic arm_set,
    input logic arm_clr,
    input logic mem_mode,
    input logic arm,
    input logic sclk,
    input logic sdo_a,
    input logic sdo_b,
    input logic ld
);
    int hi_len;
    int ld_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len <= 0;
            ld_len <= 0;
        end else begin
            hi_len <= sclk ? hi_len + 1 : 0;
            ld_len <= ld   ? ld_len + 1 : 0;
        end
    end

    a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(sdo_a) && $stable(sdo_b)));

    a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_len == HALF_DIV));

    a_r5_clock_low_in_load: assert property (@(posedge clk) disable iff (rst)
        ld |-> !sclk);

    a_r5_load_width: assert property (@(posedge clk) disable iff (rst)
        $fell(ld) |-> (ld_len == 2 * LOAD_PERIODS * HALF_DIV));

    a_r6_arm_clears_at_load_end: assert property (@(posedge clk) disable iff (rst)
        $fell(arm) |-> ($past(arm_clr) || ($past(ld) && !$past(mem_mode))));

    a_r7_mem_mode_holds_arm: assert property (@(posedge clk) disable iff (rst)
        (arm && mem_mode && !arm_clr) |=> arm);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        arm_set |=> arm);
endmodule

bind dac_chain_loader dac_chain_loader_chk #(
    .HALF_DIV(HALF_DIV), .LOAD_PERIODS(LOAD_PERIODS)
) u_chk (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr),
    .mem_mode(mem_mode), .arm(arm), .sclk(sclk), .sdo_a(sdo_a),
    .sdo_b(sdo_b), .ld(ld)
);

// File: tb/dac_chain_loader_test.sv
`timescale 1ns/1ps
module dac_chain_loader_test;
    localparam int CPB = 8;
    localparam int H   = 2;
    localparam int LP  = 2;
    localparam int NCH = 2 * CPB;
    localparam int LAT = 1 + 64 * CPB * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_cmd = 1'b0;
    logic [3:0] wr_ch = '0;
    logic [15:0] wr_data = '0;
    logic arm_set = 1'b0, arm_clr = 1'b0, mem_mode = 1'b0;
    logic arm, sclk, sdo_a, sdo_b, ld;

    always #2 clk = ~clk;

    dac_chain_loader #(.CH_PER_BANK(CPB), .HALF_DIV(H), .LOAD_PERIODS(LP)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_ch(wr_ch),
        .wr_data(wr_data), .arm_set(arm_set), .arm_clr(arm_clr),
        .mem_mode(mem_mode), .arm(arm), .sclk(sclk), .sdo_a(sdo_a),
        .sdo_b(sdo_b), .ld(ld)
    );

    int checks = 0, failures = 0, cyc = 0, passes = 0, rises = 0, ld_len = 0;
    bit done = 0;
    logic [3:0]  m_code [NCH];
    logic [15:0] m_val  [NCH];
    logic [3:0]  s_code [NCH];
    logic [15:0] s_val  [NCH];
    logic [31:0] got_frame [NCH];
    bit qa[$];
    bit qb[$];
    logic prev_sclk = 0, prev_ld = 0, prev_a = 0, prev_b = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expf(input logic [3:0] c, input logic [15:0] v);
        return {8'h00, c, 4'h0, v};
    endfunction

    // behavioural reference: collects bits at rising sclk and checks every clock
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sclk && prev_sclk)
                chk(sdo_a == prev_a && sdo_b == prev_b, "R4 data moved while sclk high",
                    {sdo_a, sdo_b}, {prev_a, prev_b});
            if (sclk && !prev_sclk) begin
                if (qa.size() == 0) begin
                    s_code = m_code;
                    s_val  = m_val;
                end
                qa.push_back(sdo_a);
                qb.push_back(sdo_b);
                rises++;
            end
            if (ld) ld_len++;
            if (prev_ld && !ld) begin
                chk(qa.size() == 32 * CPB && qb.size() == 32 * CPB, "R1 bits per chain",
                    qa.size(), 32 * CPB);
                for (int i = 0; i < CPB; i++) begin
                    logic [31:0] ga, gb;
                    ga = '0; gb = '0;
                    for (int b = 0; b < 32; b++) begin
                        ga = {ga[30:0], qa[i*32+b]};
                        gb = {gb[30:0], qb[i*32+b]};
                    end
                    got_frame[CPB-1-i] = ga;
                    got_frame[NCH-1-i] = gb;
                    chk(ga == expf(s_code[CPB-1-i], s_val[CPB-1-i]), "R1/R3 bank A frame",
                        ga, expf(s_code[CPB-1-i], s_val[CPB-1-i]));
                    chk(gb == expf(s_code[NCH-1-i], s_val[NCH-1-i]), "R1/R3 bank B frame",
                        gb, expf(s_code[NCH-1-i], s_val[NCH-1-i]));
                end
                chk(ld_len == 2 * LP * H, "R5 load pulse width", ld_len, 2 * LP * H);
                ld_len = 0;
                qa.delete();
                qb.delete();
                passes++;
            end
        end
        prev_sclk = sclk; prev_ld = ld; prev_a = sdo_a; prev_b = sdo_b;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input bit cmd, input int ch, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_cmd = cmd; wr_ch = 4'(ch); wr_data = d;
        if (cmd) m_code[ch] = d[7:4]; else m_val[ch] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic arm_and_time();
        int n;
        @(negedge clk); arm_set = 1;
        @(negedge clk); arm_set = 0;
        n = 0;
        while (!ld) begin @(negedge clk); n++; end
        chk(n == LAT, "R10 arm to load latency", n, LAT);
    endtask

    task automatic wait_passes(input int n);
        while (passes < n) @(negedge clk);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int r0;
        r0 = rises;
        repeat (cycles) @(negedge clk);
        chk(rises == r0 && !ld, tag, rises - r0, 0);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin m_code[i] = '0; m_val[i] = '0; end
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({arm, sclk, ld, sdo_a, sdo_b} == 5'b0, "R8 reset outputs", {arm, sclk, ld, sdo_a, sdo_b}, 0);

        // R8: unwritten registers send zero frames; R6 self clear
        arm_and_time();
        wait_passes(1);
        @(negedge clk);
        chk(arm == 0, "R6 arm cleared after register-mode pass", arm, 0);

        // R2: junk around the code field must not reach the frame
        for (int c = 0; c < NCH; c++) begin
            wr(1, c, 16'hF00F | 16'((8 + (c % 5)) << 4));
            wr(0, c, 16'hA5C3 ^ 16'(c * 16'h1111));
        end
        arm_and_time();
        wait_passes(2);
        @(negedge clk);
        chk(arm == 0, "R6 arm cleared", arm, 0);
        chk(got_frame[4][31:16] == 16'h00C0, "R2 command word ch5", got_frame[4][31:16], 16'h00C0);
        quiet(300, "R6 no pass after self clear");

        // R7: memory mode repeats and picks up writes made during the strobe
        mem_mode = 1;
        @(negedge clk); arm_set = 1;
        @(negedge clk); arm_set = 0;
        while (!ld) @(negedge clk);
        wr(0, 2, 16'hBEEF);
        wr(1, 12, 16'h0039);
        wait_passes(4);
        chk(got_frame[2] == {16'h00A0, 16'hBEEF}, "R7 rewritten data in next pass",
            got_frame[2], {16'h00A0, 16'hBEEF});
        chk(got_frame[12][31:16] == 16'h0030, "R7 rewritten command in next pass",
            got_frame[12][31:16], 16'h0030);
        chk(arm == 1, "R7 arm held in memory mode", arm, 1);

        // R9: clear mid-pass lets the pass finish, then stops
        while (!sclk) @(negedge clk);
        arm_clr = 1;
        @(negedge clk); arm_clr = 0;
        chk(arm == 0, "R9 arm cleared by arm_clr", arm, 0);
        wait_passes(5);
        quiet(300, "R9 no pass after clear");
        mem_mode = 0;

        // R9: set wins over clear in the same cycle
        @(negedge clk); arm_set = 1; arm_clr = 1;
        @(negedge clk); arm_set = 0; arm_clr = 0;
        chk(arm == 1, "R9 set wins over clear", arm, 1);
        wait_passes(6);
        @(negedge clk);
        chk(arm == 0, "R6 arm cleared after final pass", arm, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule